// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block holds six 40-bit event counters for a processor core. Each counter has its own event pulse input. A counter advances by one on its pulse when three things hold: its count enable is set, counting is not frozen or held, and the privilege level of the core in that cycle is one that software has allowed. To sample every N events, software loads a counter with 2^39 − N. The top bit of a counter is the overflow mark. When a counted event first sets that bit on a counter whose interrupt enable is on, the block does three things: it records the instruction address presented with that event, sets a single shared "sample logged" flag, and sets a hold bit that stops all counting. The hold stays in place until the core signals a return from interrupt.

Software reaches the counters and the two control words through a flat register port. Writes take effect at the clock edge and reads are combinational. The monitor interrupt is a level signal. It stays high while any interrupt-enabled counter has its top bit set. The processor decodes events elsewhere and delivers them here as pulses.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, every counter, both control words and the sample address read zero, and `pmi_irq` is low.
- R2: Register index 0..5 selects counters 0..5 (40 bits, read zero-extended), 6 selects control word A, 7 selects control word B (all 64 bits kept), and 8 selects the sample address. The sample address ignores writes.
- R3: Counter n goes up by exactly one on a cycle with `event_pulse[n]` high when control word A bit n is set and counting is allowed. In every other case it keeps its value.
- R4: Counting is allowed only when the privilege-enable bit for `priv_mode` is set. Code 0 (user) uses bit 24, code 1 (supervisor) uses bit 25, code 2 (hypervisor) uses bit 26. Code 3 never counts.
- R5: While control word A bit 27 (freeze) is set, no counter advances.
- R6: Writing control word B leaves every counter unchanged.
- R7: `pmi_irq` is high exactly when some counter n has bit 39 set and control word A bit n+12 is set. It falls once such counters are rewritten with bit 39 clear.
- R8: If a counted event takes counter n's bit 39 from 0 to 1 while bit n+12 is set, the sample address takes `event_pc` from that cycle, and control word A bit 29 (sample logged) and bit 28 (hold) are set. While bit 28 is set, nothing counts.
- R9: `rfi_strobe` clears bit 28 at the next edge, and counting resumes from the cycle after. If a new overflow capture occurs in the same cycle, the hold is set anyway.
- R10: A software write to a counter in the same cycle as its event pulse loads the written value and drops the event.
- R11: An overflow on a counter whose interrupt enable is clear does not capture, does not set hold, and does not raise the interrupt. The counter keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the indexed register |
| event_pulse | input | 6 | One event pulse per counter |
| priv_mode | input | 2 | Current privilege level of the core |
| event_pc | input | 64 | Instruction address tied to this cycle's events |
| rfi_strobe | input | 1 | Return-from-interrupt pulse |
| pmi_irq | output | 1 | Monitor interrupt, level |

## Verification
The properties assume that `reg_addr` is driven with a defined value and that `priv_mode` is always a defined two-bit code. The freeze and privilege properties also assume that no register write arrives in the cycle they observe, and they are conditioned on that. The stimulus never leaves a write strobe high for longer than one cycle. It drives every input to a known idle value between steps, so the properties see only defined values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   // control word A field positions
   localparam int IEN_BASE   = 12;
   localparam int BIT_USER   = 24;
   localparam int BIT_SUPV   = 25;
   localparam int BIT_HYPV   = 26;
   localparam int BIT_FREEZE = 27;
   localparam int BIT_HOLD   = 28;
   localparam int BIT_SMPL   = 29;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_SUPV = 2'd1,
      PRIV_HYPV = 2'd2,
      PRIV_NONE = 2'd3
   } priv_e;
endpackage

// File: rtl/pmu_gate.sv
module pmu_gate
   import pmu_pkg::*;
(
   input  logic [1:0] priv_mode,
   input  logic       en_user,
   input  logic       en_supv,
   input  logic       en_hypv,
   input  logic       freeze,
   input  logic       hold,
   output logic       count_allowed
);
   logic priv_ok;

   always_comb begin
      case (priv_e'(priv_mode))
         PRIV_USER: priv_ok = en_user;
         PRIV_SUPV: priv_ok = en_supv;
         PRIV_HYPV: priv_ok = en_hypv;
         default:   priv_ok = 1'b0;
      endcase
      count_allowed = priv_ok & ~freeze & ~hold;
   end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CTR_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CTR_W-1:0] load_val,
   input  logic             bump,
   output logic [CTR_W-1:0] cnt_q,
   output logic             ovf_rise
);
   localparam int MSB = CTR_W - 1;

   logic [CTR_W-1:0] cnt_inc;

   generate
      if (CTR_W < 2) begin : g_bad_width
         $error("pmu_counter: CTR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      cnt_inc  = cnt_q + CTR_W'(1);
      ovf_rise = bump & ~load & ~cnt_q[MSB] & cnt_inc[MSB];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (bump) cnt_q <= cnt_inc;
   end

   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

   p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !bump) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_ctl.sv
module pmu_ctl
   import pmu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int PC_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rfi_strobe,
   input  logic              capture,
   input  logic [PC_W-1:0]   event_pc,
   output logic [DATA_W-1:0] ctl_a_q,
   output logic [DATA_W-1:0] ctl_b_q,
   output logic [PC_W-1:0]   sample_q
);
   logic [DATA_W-1:0] ctl_a_d;

   generate
      if (DATA_W <= BIT_SMPL) begin : g_bad_data
         $error("pmu_ctl: DATA_W too narrow for control fields");
      end
   endgenerate

   always_comb begin
      ctl_a_d = wr_a ? wdata : ctl_a_q;
      if (rfi_strobe) ctl_a_d[BIT_HOLD] = 1'b0;
      if (capture) begin
         ctl_a_d[BIT_HOLD] = 1'b1;
         ctl_a_d[BIT_SMPL] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_a_q  <= '0;
         ctl_b_q  <= '0;
         sample_q <= '0;
      end else begin
         ctl_a_q <= ctl_a_d;
         if (wr_b)    ctl_b_q  <= wdata;
         if (capture) sample_q <= event_pc;
      end
   end

   p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (ctl_a_q[BIT_HOLD] && ctl_a_q[BIT_SMPL] && sample_q == $past(event_pc)));

   p_rfi_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rfi_strobe && !capture) |=> !ctl_a_q[BIT_HOLD]);
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
   import pmu_pkg::*;
#(
   parameter int NUM_CTR   = 6,
   parameter int CTR_W     = 40,
   parameter int DATA_W    = 64,
   parameter int PC_W      = 64,
   parameter int REG_IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_CTR-1:0]   event_pulse,
   input  logic [1:0]           priv_mode,
   input  logic [PC_W-1:0]      event_pc,
   input  logic                 rfi_strobe,
   output logic                 pmi_irq
);
   localparam int IDX_A   = NUM_CTR;
   localparam int IDX_B   = NUM_CTR + 1;
   localparam int IDX_SMP = NUM_CTR + 2;

   generate
      if (NUM_CTR < 1 || NUM_CTR > IEN_BASE) begin : g_bad_num
         $error("pmu_counter_unit: NUM_CTR out of range");
      end
      if ((1 << REG_IDX_W) < NUM_CTR + 3) begin : g_bad_idx
         $error("pmu_counter_unit: REG_IDX_W too small");
      end
      if (CTR_W > DATA_W || PC_W > DATA_W) begin : g_bad_w
         $error("pmu_counter_unit: counter or PC wider than data");
      end
   endgenerate

   logic [DATA_W-1:0]          ctl_a_q, ctl_b_q;
   logic [PC_W-1:0]            sample_q;
   logic                       count_allowed;
   logic [NUM_CTR-1:0]         cnt_en, irq_en, load_vec, bump_vec, rise_vec, top_bits;
   logic [NUM_CTR*CTR_W-1:0]   cnt_flat;
   logic [CTR_W-1:0]           cnt_arr [NUM_CTR];
   logic                       capture;

   assign cnt_en = ctl_a_q[NUM_CTR-1:0];
   assign irq_en = ctl_a_q[IEN_BASE +: NUM_CTR];

   pmu_gate u_gate (
      .priv_mode     (priv_mode),
      .en_user       (ctl_a_q[BIT_USER]),
      .en_supv       (ctl_a_q[BIT_SUPV]),
      .en_hypv       (ctl_a_q[BIT_HYPV]),
      .freeze        (ctl_a_q[BIT_FREEZE]),
      .hold          (ctl_a_q[BIT_HOLD]),
      .count_allowed (count_allowed)
   );

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         assign load_vec[i] = reg_wr_en && (reg_addr == REG_IDX_W'(i));
         assign bump_vec[i] = event_pulse[i] & cnt_en[i] & count_allowed;

         pmu_counter #(.CTR_W(CTR_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_vec[i]),
            .load_val (reg_wdata[CTR_W-1:0]),
            .bump     (bump_vec[i]),
            .cnt_q    (cnt_arr[i]),
            .ovf_rise (rise_vec[i])
         );

         assign top_bits[i]                 = cnt_arr[i][CTR_W-1];
         assign cnt_flat[i*CTR_W +: CTR_W]  = cnt_arr[i];
      end
   endgenerate

   assign capture = |(rise_vec & irq_en);
   assign pmi_irq = |(top_bits & irq_en);

   pmu_ctl #(.DATA_W(DATA_W), .PC_W(PC_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_a       (reg_wr_en && reg_addr == REG_IDX_W'(IDX_A)),
      .wr_b       (reg_wr_en && reg_addr == REG_IDX_W'(IDX_B)),
      .wdata      (reg_wdata),
      .rfi_strobe (rfi_strobe),
      .capture    (capture),
      .event_pc   (event_pc),
      .ctl_a_q    (ctl_a_q),
      .ctl_b_q    (ctl_b_q),
      .sample_q   (sample_q)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CTR; i++)
         if (reg_addr == REG_IDX_W'(i)) reg_rdata = DATA_W'(cnt_arr[i]);
      if (reg_addr == REG_IDX_W'(IDX_A))   reg_rdata = ctl_a_q;
      if (reg_addr == REG_IDX_W'(IDX_B))   reg_rdata = ctl_b_q;
      if (reg_addr == REG_IDX_W'(IDX_SMP)) reg_rdata = DATA_W'(sample_q);
   end

   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a_q[BIT_FREEZE] && !reg_wr_en) |=> $stable(cnt_flat));

   p_no_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_mode == 2'd3 && !reg_wr_en) |=> $stable(cnt_flat));

   p_irq_from_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pmi_irq) && !$past(reg_wr_en)) |-> ctl_a_q[BIT_HOLD]);
endmodule

// File: tb/pmu_counter_unit_test.sv
module pmu_counter_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic [5:0]  event_pulse = '0;
   logic [1:0]  priv_mode = '0;
   logic [63:0] event_pc = '0;
   logic        rfi_strobe = 1'b0;
   logic        pmi_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [63:0] TOP = 64'h80_0000_0000;

   always #4 clk = ~clk;

   pmu_counter_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_pulse(event_pulse),
      .priv_mode(priv_mode), .event_pc(event_pc), .rfi_strobe(rfi_strobe),
      .pmi_irq(pmi_irq)
   );

   typedef struct packed {
      logic        wr;
      logic [3:0]  addr;
      logic [63:0] wdata;
      logic [5:0]  evt;
      logic [1:0]  priv;
      logic [3:0]  chk;
      logic [63:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd6, 64'h0100_0003, 6'h00, 2'd0, 4'd6, 64'h0100_0003},            // R2 ctl A
      '{1'b1, 4'd0, 64'd5,         6'h00, 2'd0, 4'd0, 64'd5},                    // R2 counter load
      '{1'b0, 4'd0, 64'd0,         6'h01, 2'd0, 4'd0, 64'd6},                    // R3 count
      '{1'b0, 4'd0, 64'd0,         6'h01, 2'd1, 4'd0, 64'd6},                    // R4 supv off
      '{1'b0, 4'd0, 64'd0,         6'h02, 2'd0, 4'd1, 64'd1},                    // R3 ctr1
      '{1'b0, 4'd0, 64'd0,         6'h04, 2'd0, 4'd2, 64'd0},                    // R3 ctr2 disabled
      '{1'b1, 4'd7, 64'hDEAD_BEEF_1234_5678, 6'h00, 2'd0, 4'd0, 64'd6},          // R6
      '{1'b0, 4'd0, 64'd0,         6'h00, 2'd0, 4'd7, 64'hDEAD_BEEF_1234_5678},  // R2 ctl B
      '{1'b1, 4'd6, 64'h0900_0003, 6'h00, 2'd0, 4'd6, 64'h0900_0003},            // R5 freeze on
      '{1'b0, 4'd0, 64'd0,         6'h03, 2'd0, 4'd0, 64'd6},                    // R5 frozen
      '{1'b1, 4'd6, 64'h0700_0003, 6'h00, 2'd0, 4'd6, 64'h0700_0003},            // R4 all priv
      '{1'b0, 4'd0, 64'd0,         6'h01, 2'd2, 4'd0, 64'd7},                    // R4 hypv
      '{1'b0, 4'd0, 64'd0,         6'h01, 2'd3, 4'd0, 64'd7},                    // R4 code 3
      '{1'b1, 4'd0, 64'd100,       6'h01, 2'd0, 4'd0, 64'd100}                   // R10
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_check(input string req, input logic [3:0] a, input logic [63:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic step(input logic wr, input logic [3:0] a, input logic [63:0] d,
                       input logic [5:0] ev, input logic [1:0] pv, input logic rfi,
                       input logic [63:0] pc);
      reg_wr_en = wr; reg_addr = a; reg_wdata = d; event_pulse = ev;
      priv_mode = pv; rfi_strobe = rfi; event_pc = pc;
      @(posedge clk);
      #2;
      reg_wr_en = 1'b0; event_pulse = '0; rfi_strobe = 1'b0; event_pc = '0; priv_mode = 2'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 9; a++) rd_check("R1", 4'(a), 64'd0);
      check("R1 irq", {63'd0, pmi_irq}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].evt, VEC[i].priv, 1'b0, 64'd0);
         rd_check($sformatf("R-vector %0d", i), VEC[i].chk, VEC[i].exp);
      end

      // R7 / R8 overflow with interrupt enable
      step(1'b1, 4'd6, 64'h0100_1001, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b1, 4'd0, TOP - 2, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h1000);
      rd_check("R8 pre", 4'd0, TOP - 1);
      check("R7 low before", {63'd0, pmi_irq}, 64'd0);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h2000);
      rd_check("R8 ctr", 4'd0, TOP);
      check("R7 high", {63'd0, pmi_irq}, 64'd1);
      rd_check("R8 sample", 4'd8, 64'h2000);
      rd_check("R8 flags", 4'd6, 64'h3100_1001);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h2400);
      rd_check("R8 held", 4'd0, TOP);
      step(1'b1, 4'd8, 64'h5555, 6'h00, 2'd0, 1'b0, 64'd0);
      rd_check("R2 sample ro", 4'd8, 64'h2000);
      // R9 release: event in the rfi cycle is still held
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b1, 64'h3000);
      rd_check("R9 rfi cycle", 4'd0, TOP);
      rd_check("R9 hold clear", 4'd6, 64'h2100_1001);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h3100);
      rd_check("R9 resume", 4'd0, TOP + 1);
      rd_check("R9 no recapture", 4'd8, 64'h2000);
      step(1'b1, 4'd0, 64'd10, 6'h00, 2'd0, 1'b0, 64'd0);
      check("R7 falls", {63'd0, pmi_irq}, 64'd0);

      // R11 overflow without interrupt enable
      step(1'b1, 4'd6, 64'h0100_0001, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b1, 4'd0, TOP - 1, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h4000);
      rd_check("R11 ctr", 4'd0, TOP);
      check("R11 irq", {63'd0, pmi_irq}, 64'd0);
      rd_check("R11 ctl", 4'd6, 64'h0100_0001);
      rd_check("R11 sample", 4'd8, 64'h2000);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b0, 64'h4100);
      rd_check("R11 keeps counting", 4'd0, TOP + 1);

      // R9 capture wins over rfi in the same cycle
      step(1'b1, 4'd6, 64'h0100_1001, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b1, 4'd0, TOP - 1, 6'h00, 2'd0, 1'b0, 64'd0);
      step(1'b0, 4'd0, 64'd0, 6'h01, 2'd0, 1'b1, 64'h6000);
      rd_check("R9 set wins", 4'd6, 64'h3100_1001);
      rd_check("R8 sample 2", 4'd8, 64'h6000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule